// File: doc/BRIEF.md
# Reservation Station Pool with Result-Bus Wakeup

This block holds in-flight arithmetic instructions between issue and write-back for two classes of functional unit: an add/subtract class and a multiply/divide class. At issue the front end supplies an operation and, for each source, either a ready value (tag zero) or the tag of the entry that will produce it. The pool picks a free entry of the matching class, marks it busy and hands back that entry's tag, so that the front end can record it as the pending producer of the destination register.

Each waiting entry watches the pool's single result bus. When the tag it needs appears there, it copies the value in. Once both sources are present, a per-entry countdown models the unit's latency. When that countdown expires, the entry asks for the result bus. A fixed-priority arbiter grants the bus to one entry per cycle, and that entry is freed when its broadcast ends. Independent instructions can therefore finish out of program order. The arithmetic is a plain integer stand-in for the real units.

Top module: `rs_pool`

## Requirements
- R1: After reset no entry is busy, `cdb_valid_o` is low, and both classes report `issue_ready_o` high.
- R2: Operation codes are 0 add, 1 subtract, 2 multiply and 3 divide. Tags 1 to 3 name the add/subtract entries and tags 4 and 5 name the multiply/divide entries. Tag 0 marks a source value as already valid. `issue_tag_o` shows the lowest-numbered free entry of the class chosen by `issue_op_i`, and every broadcast carries a non-zero tag.
- R3: An entry is allocated only when `issue_valid_i` is high and a free entry of the required class exists. When the class is full, `issue_ready_o` is low, the issue is dropped and produces no broadcast, and the other class stays available.
- R4: An entry executes only while both of its producer tags are clear. Add and subtract take 2 cycles, multiply 10 and divide 40. If an instruction is issued in cycle t with both sources ready, its result is on the bus in cycle t+L+1, where L is its latency.
- R5: A waiting entry whose Qj or Qk matches the tag on the bus takes the bus value into that source and clears the tag. If that completes its sources, it executes in the following cycles, so its result appears L+1 cycles after the producer's broadcast.
- R6: An instruction issued in the same cycle that its producer broadcasts takes the value straight from the bus and does not wait on that tag.
- R7: The bus carries at most one result per cycle. Finished entries are granted in order of lowest entry index. An entry that loses arbitration keeps its result unchanged and is granted in a later cycle.
- R8: A broadcasting entry is freed at the end of its broadcast cycle and can be allocated again from the next cycle.
- R9: Results are DATA_W bits wide. Add and subtract wrap modulo 2^DATA_W. Multiply returns the low DATA_W bits of the product. Divide returns the unsigned quotient, or all ones when the divisor is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Issue request |
| issue_op_i | input | 2 | Operation code |
| issue_vj_i | input | DATA_W | First source value, used when issue_qj_i is 0 |
| issue_qj_i | input | TAG_W | Producer tag of the first source, 0 if ready |
| issue_vk_i | input | DATA_W | Second source value, used when issue_qk_i is 0 |
| issue_qk_i | input | TAG_W | Producer tag of the second source, 0 if ready |
| issue_ready_o | output | 1 | A free entry exists for the class of issue_op_i |
| issue_tag_o | output | TAG_W | Tag of the entry that the issue would take |
| cdb_valid_o | output | 1 | Result bus carries a result |
| cdb_tag_o | output | TAG_W | Tag of the producing entry |
| cdb_data_o | output | DATA_W | Result value |

## Verification
Every result has a due cycle that follows from the moment its sources become ready: L+1 cycles after an issue with ready operands, or L+1 cycles after the producer's broadcast for a waiting instruction. Arbitration losers come one cycle later per entry ahead of them. A monitor logs the tag, value and cycle number of every broadcast, sampling on the falling clock edge, and the bench compares each log entry with values it computes itself from the operands and latencies. This covers same-cycle bypass, a full class, the simultaneous wakeup of three entries, and reuse of a freed entry in the cycle after its broadcast. Readiness and tag outputs are read just after the bench drives the operation code, within the same cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } rs_op_e;

  function automatic logic is_mul_class(rs_op_e op);
    return (op == OP_MUL) || (op == OP_DIV);
  endfunction
endpackage

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int N_ENT = 5,
  parameter int N_ADD = 3,
  parameter int TAG_W = 3
) (
  input  logic [N_ENT-1:0] busy_i,
  input  logic             mul_cls_i,
  output logic             free_o,
  output logic [N_ENT-1:0] sel_o,
  output logic [TAG_W-1:0] tag_o
);
  always_comb begin
    sel_o  = '0;
    free_o = 1'b0;
    tag_o  = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (((mul_cls_i && i >= N_ADD) || (!mul_cls_i && i < N_ADD)) && !busy_i[i] && !free_o) begin
        sel_o[i] = 1'b1;
        free_o   = 1'b1;
        tag_o    = TAG_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/rs_arb.sv
module rs_arb #(
  parameter int N_ENT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ENT-1:0] req_i,
  output logic [N_ENT-1:0] grant_o
);
  always_comb begin
    grant_o = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (req_i[i] && grant_o == '0) grant_o[i] = 1'b1;
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)) else $error("multiple grants"); // R7
  AST_GRANT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> (grant_o != '0)) else $error("request left idle"); // R7
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int TAG_W   = 3,
  parameter int CNT_W   = 6,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  rs_op_e            op_i,
  input  logic [DATA_W-1:0] vj_i,
  input  logic [TAG_W-1:0]  qj_i,
  input  logic [DATA_W-1:0] vk_i,
  input  logic [TAG_W-1:0]  qk_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  input  logic              grant_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);
  rs_op_e            op_q;
  logic [DATA_W-1:0] vj_q, vk_q, res_q;
  logic [TAG_W-1:0]  qj_q, qk_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, done_q;

  // issue-time bypass from the bus
  logic              byp_j, byp_k;
  logic [DATA_W-1:0] vj_in, vk_in;
  logic [TAG_W-1:0]  qj_in, qk_in;
  logic              hit_j, hit_k, ready;

  assign byp_j = cdb_valid_i && (qj_i != '0) && (qj_i == cdb_tag_i);
  assign byp_k = cdb_valid_i && (qk_i != '0) && (qk_i == cdb_tag_i);
  assign vj_in = byp_j ? cdb_data_i : vj_i;
  assign vk_in = byp_k ? cdb_data_i : vk_i;
  assign qj_in = byp_j ? '0 : qj_i;
  assign qk_in = byp_k ? '0 : qk_i;

  assign hit_j = cdb_valid_i && (qj_q != '0) && (qj_q == cdb_tag_i);
  assign hit_k = cdb_valid_i && (qk_q != '0) && (qk_q == cdb_tag_i);
  assign ready = (qj_q == '0) && (qk_q == '0);

  function automatic logic [CNT_W-1:0] lat_of(rs_op_e op);
    case (op)
      OP_MUL:  return CNT_W'(LAT_MUL);
      OP_DIV:  return CNT_W'(LAT_DIV);
      default: return CNT_W'(LAT_ADD);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] calc(rs_op_e op, logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_MUL:  return a * b;
      default: return (b == '0) ? '1 : a / b;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_ADD;
      vj_q   <= '0;
      vk_q   <= '0;
      qj_q   <= '0;
      qk_q   <= '0;
      res_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (alloc_i) begin
      op_q   <= op_i;
      vj_q   <= vj_in;
      vk_q   <= vk_in;
      qj_q   <= qj_in;
      qk_q   <= qk_in;
      cnt_q  <= lat_of(op_i);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      if (grant_i) begin
        busy_q <= 1'b0;
        done_q <= 1'b0;
      end else begin
        if (hit_j) begin
          vj_q <= cdb_data_i;
          qj_q <= '0;
        end
        if (hit_k) begin
          vk_q <= cdb_data_i;
          qk_q <= '0;
        end
        if (!done_q && ready) begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) begin
            done_q <= 1'b1;
            res_q  <= calc(op_q, vj_q, vk_q);
          end
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;

  AST_ALLOC_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !busy_q) else $error("alloc into busy entry"); // R3
  AST_WAIT_OPERAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_q && !ready && !alloc_i) |=> !done_q) else $error("finished without operands"); // R4
  AST_GRANT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> (busy_q && done_q)) else $error("grant to unfinished entry"); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !grant_i) |=> (done_q && $stable(res_q))) else $error("loser lost result"); // R7
  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |=> !busy_q) else $error("entry not freed"); // R8
endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int N_ADD   = 3,
  parameter int N_MUL   = 2,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40,
  localparam int N_ENT   = N_ADD + N_MUL,
  localparam int TAG_W   = $clog2(N_ENT + 1),
  localparam int LAT_MAX = (LAT_DIV > LAT_MUL) ? ((LAT_DIV > LAT_ADD) ? LAT_DIV : LAT_ADD)
                                               : ((LAT_MUL > LAT_ADD) ? LAT_MUL : LAT_ADD),
  localparam int CNT_W   = $clog2(LAT_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic [1:0]        issue_op_i,
  input  logic [DATA_W-1:0] issue_vj_i,
  input  logic [TAG_W-1:0]  issue_qj_i,
  input  logic [DATA_W-1:0] issue_vk_i,
  input  logic [TAG_W-1:0]  issue_qk_i,
  output logic              issue_ready_o,
  output logic [TAG_W-1:0]  issue_tag_o,
  output logic              cdb_valid_o,
  output logic [TAG_W-1:0]  cdb_tag_o,
  output logic [DATA_W-1:0] cdb_data_o
);
  rs_op_e            op;
  logic [N_ENT-1:0]  busy, done, grant, sel, alloc;
  logic [DATA_W-1:0] res [N_ENT];
  logic              free;

  assign op = rs_op_e'(issue_op_i);

  rs_alloc #(.N_ENT(N_ENT), .N_ADD(N_ADD), .TAG_W(TAG_W)) u_alloc (
    .busy_i    (busy),
    .mul_cls_i (is_mul_class(op)),
    .free_o    (free),
    .sel_o     (sel),
    .tag_o     (issue_tag_o)
  );

  assign issue_ready_o = free;
  assign alloc         = issue_valid_i ? sel : '0;

  rs_arb #(.N_ENT(N_ENT)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (done),
    .grant_o (grant)
  );

  always_comb begin
    cdb_valid_o = 1'b0;
    cdb_tag_o   = '0;
    cdb_data_o  = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (grant[i]) begin
        cdb_valid_o = 1'b1;
        cdb_tag_o   = TAG_W'(i + 1);
        cdb_data_o  = res[i];
      end
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    rs_entry #(
      .DATA_W(DATA_W), .TAG_W(TAG_W), .CNT_W(CNT_W),
      .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
    ) u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (alloc[g]),
      .op_i        (op),
      .vj_i        (issue_vj_i),
      .qj_i        (issue_qj_i),
      .vk_i        (issue_vk_i),
      .qk_i        (issue_qk_i),
      .cdb_valid_i (cdb_valid_o),
      .cdb_tag_i   (cdb_tag_o),
      .cdb_data_i  (cdb_data_o),
      .grant_i     (grant[g]),
      .busy_o      (busy[g]),
      .done_o      (done[g]),
      .result_o    (res[g])
    );
  end

  AST_BUS_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdb_valid_o |-> (cdb_tag_o != '0)) else $error("zero tag on bus"); // R2
  AST_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && !issue_ready_o) |=> ($countones(busy) <= $countones($past(busy))))
    else $error("issue into full class"); // R3
endmodule

// File: tb/rs_pool_tb.sv
`timescale 1ns/1ps
module rs_pool_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [1:0]  issue_op = 2'd0;
  logic [15:0] issue_vj = '0, issue_vk = '0;
  logic [2:0]  issue_qj = '0, issue_qk = '0;
  logic        issue_ready;
  logic [2:0]  issue_tag;
  logic        cdb_valid;
  logic [2:0]  cdb_tag;
  logic [15:0] cdb_data;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int lcnt = 0;
  int log_tag [64];
  int log_dat [64];
  int log_cyc [64];

  always #2 clk = ~clk;

  rs_pool u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .issue_valid_i(issue_valid), .issue_op_i(issue_op),
    .issue_vj_i(issue_vj), .issue_qj_i(issue_qj),
    .issue_vk_i(issue_vk), .issue_qk_i(issue_qk),
    .issue_ready_o(issue_ready), .issue_tag_o(issue_tag),
    .cdb_valid_o(cdb_valid), .cdb_tag_o(cdb_tag), .cdb_data_o(cdb_data)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n && cdb_valid && lcnt < 64) begin
      log_tag[lcnt] = int'(cdb_tag);
      log_dat[lcnt] = int'(cdb_data);
      log_cyc[lcnt] = cyc;
      lcnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_log(input int idx, input string req, input int tag, input int dat, input int c);
    if (idx >= lcnt) begin
      chk({req, " missing broadcast"}, -1, tag);
    end else begin
      chk({req, " tag"}, log_tag[idx], tag);
      chk({req, " data"}, log_dat[idx], dat);
      chk({req, " cycle"}, log_cyc[idx], c);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [15:0] vj, input logic [2:0] qj,
                       input logic [15:0] vk, input logic [2:0] qk,
                       output int t, output int rdy, output int tag);
    issue_valid = 1'b1;
    issue_op = op; issue_vj = vj; issue_qj = qj; issue_vk = vk; issue_qk = qk;
    #1;
    rdy = int'(issue_ready);
    tag = int'(issue_tag);
    t = cyc;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (all requirements) actual=%0d expected=<20000", cyc);
    summary();
    $finish;
  end

  initial begin
    int t0, t1, ta, r, g, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 first free tags per class
    issue_op = 2'd0; #1;
    chk("R1 add ready", int'(issue_ready), 1);
    chk("R2 add tag", int'(issue_tag), 1);
    chk("R1 bus idle", int'(cdb_valid), 0);
    issue_op = 2'd2; #1;
    chk("R1 mul ready", int'(issue_ready), 1);
    chk("R2 mul tag", int'(issue_tag), 4);
    @(negedge clk);

    // R4 add latency, R9 add
    b = lcnt;
    issue(2'd0, 16'd5, 3'd0, 16'd7, 3'd0, t0, r, g);
    chk("R2 issue tag", g, 1);
    repeat (10) @(negedge clk);
    chk_log(b, "R4 R9 add", 1, 12, t0 + 3);

    // R4 R9 sub wrap, mul, div latencies
    b = lcnt;
    issue(2'd1, 16'd3, 3'd0, 16'd5, 3'd0, t1, r, g);
    issue(2'd2, 16'd300, 3'd0, 16'd300, 3'd0, ta, r, g);
    chk("R2 mul tag", g, 4);
    issue(2'd3, 16'd100, 3'd0, 16'd7, 3'd0, ta, r, g);
    chk("R2 second mul-class tag", g, 5);
    repeat (50) @(negedge clk);
    chk_log(b,     "R9 sub wrap", 1, 65534, t1 + 3);
    chk_log(b + 1, "R4 R9 mul",   4, 24464, t1 + 12);
    chk_log(b + 2, "R4 R9 div",   5, 14,    t1 + 43);
    b = lcnt;
    issue(2'd3, 16'd9, 3'd0, 16'd0, 3'd0, t0, r, g);
    repeat (50) @(negedge clk);
    chk_log(b, "R9 div by zero", 4, 65535, t0 + 41);

    // R5 wakeup on Qj and Qk, R7 ordering
    b = lcnt;
    issue(2'd2, 16'd6, 3'd0, 16'd7, 3'd0, t0, r, g);
    issue(2'd0, 16'd0, 3'd4, 16'd1, 3'd0, ta, r, g);
    issue(2'd1, 16'd50, 3'd0, 16'd0, 3'd4, ta, r, g);
    chk("R2 third tag", g, 2);
    repeat (30) @(negedge clk);
    chk_log(b,     "R5 producer",   4, 42, t0 + 11);
    chk_log(b + 1, "R5 Qj wakeup",  1, 43, t0 + 14);
    chk_log(b + 2, "R5 R7 Qk wakeup", 2, 8, t0 + 15);

    // R6 issue in the producer's broadcast cycle
    b = lcnt;
    issue(2'd2, 16'd2, 3'd0, 16'd3, 3'd0, t0, r, g);
    while (cyc != t0 + 11) @(negedge clk);
    issue(2'd0, 16'd0, 3'd4, 16'd10, 3'd0, ta, r, g);
    chk("R6 issue cycle", ta, t0 + 11);
    repeat (20) @(negedge clk);
    chk_log(b,     "R6 producer", 4, 6,  t0 + 11);
    chk_log(b + 1, "R6 bypass",   1, 16, t0 + 14);

    // R3 full class, R7 simultaneous finish, R8 reuse
    b = lcnt;
    issue(2'd3, 16'd80, 3'd0, 16'd4, 3'd0, t0, r, g);
    issue(2'd0, 16'd0, 3'd4, 16'd1, 3'd0, ta, r, g);
    issue(2'd0, 16'd0, 3'd4, 16'd2, 3'd0, ta, r, g);
    issue(2'd0, 16'd0, 3'd4, 16'd3, 3'd0, ta, r, g);
    chk("R3 last add tag", g, 3);
    issue_op = 2'd2; #1;
    chk("R3 other class ready", int'(issue_ready), 1);
    chk("R3 other class tag", int'(issue_tag), 5);
    issue(2'd0, 16'd0, 3'd0, 16'd99, 3'd0, ta, r, g);
    chk("R3 full class not ready", r, 0);
    while (cyc != t0 + 44) @(negedge clk);
    issue_op = 2'd0; #1;
    chk("R8 busy during broadcast", int'(issue_ready), 0);
    @(negedge clk);
    #1;
    chk("R8 freed next cycle", int'(issue_ready), 1);
    chk("R8 freed tag", int'(issue_tag), 1);
    repeat (20) @(negedge clk);
    chk_log(b,     "R3 producer div", 4, 20, t0 + 41);
    chk_log(b + 1, "R7 first",  1, 21, t0 + 44);
    chk_log(b + 2, "R7 second", 2, 22, t0 + 45);
    chk_log(b + 3, "R7 third",  3, 23, t0 + 46);
    chk("R3 dropped issue gives no broadcast", lcnt - b, 4);

    summary();
    $finish;
  end
endmodule